// File: doc/BRIEF.md
# Paging control register unit

This unit keeps the three control registers that steer address translation: a mode register, a translation-table base register and an extension register. It also keeps the gate that decides whether physical address line 20 passes through or is held low. Each register is loaded through its own write strobe. The unit reports the stored values and a few mode flags derived from them. It also produces the address mask that downstream address logic applies.

The unit also decides when cached translations have gone stale. On every write it compares the incoming value against the stored one on the bits that change how addresses are translated. From that comparison it raises either a full flush pulse or a non-global flush pulse on the cycle after the write. A full flush discards every cached translation. A non-global flush keeps entries marked global. A change of the line-20 gate also needs a full flush, because every mapping above 1 MiB moves.

Top module: `pgctl_unit`

## Requirements
- R1: After reset the mode register reads 0x60000010, the base and extension registers read 0, the address mask is all ones (gate open), and both flush outputs are low.
- R2: A mode write stores the written word, except that bit 4 always reads 1. The stored value appears on the cycle after the write.
- R3: A mode write raises the full flush pulse when bit 0 (protection on), bit 16 (write-protect) or bit 31 (paging on) differs from the stored value. It raises no flush when all three are unchanged.
- R4: A base write stores the word. It raises the non-global flush pulse only when the stored mode bit 31 is 1, judged on the value held before any mode write in the same cycle.
- R5: An extension write raises the full flush pulse when bit 4 (large pages), bit 5 (wide physical addresses) or bit 7 (global pages) changes. A change of any other bit raises no flush.
- R6: An extension write stores bit 9 (extended register state enable) as 0 whenever `simd_avail` is low. Otherwise the written bit is kept.
- R7: A gate write with a value different from the held gate state raises the full flush pulse. It then makes mask bit 20 equal to the new state, with all other mask bits staying 1. A gate write equal to the held state changes nothing and raises no flush.
- R8: `real_mode` is the inverse of mode bit 0. `cop_mon`, `fpu_emul` and `task_sw` follow mode bits 1, 2 and 3. `ext_state_en` follows stored extension bit 9.
- R9: The flush outputs are one-cycle pulses, high only in the cycle after the write that requested them. When a full and a non-global flush are requested in the same cycle, only the full flush pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 32 | Mode register write value |
| base_we | input | 1 | Table-base register write strobe |
| base_wdata | input | BASE_W | Table-base register write value |
| ext_we | input | 1 | Extension register write strobe |
| ext_wdata | input | 32 | Extension register write value |
| simd_avail | input | 1 | High when the SIMD feature is present |
| gate_we | input | 1 | Line-20 gate write strobe |
| gate_val | input | 1 | New line-20 gate state |
| mode_q | output | 32 | Stored mode register |
| base_q | output | BASE_W | Stored table-base register |
| ext_q | output | 32 | Stored extension register |
| real_mode | output | 1 | Protection off |
| cop_mon | output | 1 | Coprocessor monitor flag |
| fpu_emul | output | 1 | Coprocessor emulation flag |
| task_sw | output | 1 | Task-switched flag |
| ext_state_en | output | 1 | Extended register state enabled |
| addr_mask | output | ADDR_W | Physical address mask for line 20 |
| flush_all | output | 1 | Full translation flush pulse |
| flush_local | output | 1 | Non-global translation flush pulse |

## Verification
The mode register is written with words that differ from the stored value only outside the three watched bits, and then with words that flip each watched bit in turn. This separates a real mode change from an ordinary rewrite. The extension register is driven the same way, and bit 9 is written with the SIMD strap both high and low. Base writes are issued with paging off, with paging on, and in the same cycle as a flush-worthy extension write. These show the paging condition and the full-over-non-global priority. The gate is written with its held state and with the opposite state, and idle cycles follow every flush to show that the pulse ends.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;

  localparam int REG_W = 32;

  // mode register bit positions
  localparam int M_PE = 0;
  localparam int M_MP = 1;
  localparam int M_EM = 2;
  localparam int M_TS = 3;
  localparam int M_ET = 4;
  localparam int M_WP = 16;
  localparam int M_PG = 31;

  // extension register bit positions
  localparam int X_PSE   = 4;
  localparam int X_PAE   = 5;
  localparam int X_PGE   = 7;
  localparam int X_XSTEN = 9;

  localparam logic [REG_W-1:0] MODE_RESET = 32'h6000_0010;
  localparam logic [REG_W-1:0] EXT_RESET  = '0;

  typedef struct packed {
    logic real_mode;
    logic cop_mon;
    logic fpu_emul;
    logic task_sw;
  } mode_flags_t;

  function automatic logic mode_needs_full(logic [REG_W-1:0] cur, logic [REG_W-1:0] nxt);
    return (cur[M_PG] != nxt[M_PG]) || (cur[M_WP] != nxt[M_WP]) || (cur[M_PE] != nxt[M_PE]);
  endfunction

  function automatic logic [REG_W-1:0] mode_sanitize(logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    r = v;
    r[M_ET] = 1'b1;
    return r;
  endfunction

  function automatic mode_flags_t mode_decode(logic [REG_W-1:0] v);
    mode_flags_t f;
    f.real_mode = ~v[M_PE];
    f.cop_mon   = v[M_MP];
    f.fpu_emul  = v[M_EM];
    f.task_sw   = v[M_TS];
    return f;
  endfunction

  function automatic logic ext_needs_full(logic [REG_W-1:0] cur, logic [REG_W-1:0] nxt);
    return (cur[X_PGE] != nxt[X_PGE]) || (cur[X_PAE] != nxt[X_PAE]) || (cur[X_PSE] != nxt[X_PSE]);
  endfunction

  function automatic logic [REG_W-1:0] ext_sanitize(logic [REG_W-1:0] v, logic simd);
    logic [REG_W-1:0] r;
    r = v;
    if (!simd) r[X_XSTEN] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/pgctl_mode_reg.sv
module pgctl_mode_reg
  import pgctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mode_q,
  output logic             pg_en,
  output mode_flags_t      flags,
  output logic             req_full
);

  logic [REG_W-1:0] mode_next;

  assign mode_next = mode_sanitize(wdata);
  assign req_full  = we && mode_needs_full(mode_q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RESET;
    else if (we) mode_q <= mode_next;
  end

  assign pg_en = mode_q[M_PG];
  assign flags = mode_decode(mode_q);

endmodule

// File: rtl/pgctl_ext_reg.sv
module pgctl_ext_reg
  import pgctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             simd_avail,
  output logic [REG_W-1:0] ext_q,
  output logic             ext_state_en,
  output logic             req_full
);

  logic [REG_W-1:0] ext_next;

  assign ext_next = ext_sanitize(wdata, simd_avail);
  assign req_full = we && ext_needs_full(ext_q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= EXT_RESET;
    else if (we) ext_q <= ext_next;
  end

  assign ext_state_en = ext_q[X_XSTEN];

endmodule

// File: rtl/pgctl_gate_reg.sv
module pgctl_gate_reg #(
  parameter int ADDR_W   = 32,
  parameter int GATE_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              val,
  output logic              gate_q,
  output logic [ADDR_W-1:0] mask,
  output logic              req_full
);

  assign req_full = we && (val != gate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else if (req_full) gate_q <= val;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    if (i == GATE_BIT) begin : g_gated
      assign mask[i] = gate_q;
    end else begin : g_pass
      assign mask[i] = 1'b1;
    end
  end

endmodule

// File: rtl/pgctl_flush_arb.sv
module pgctl_flush_arb #(
  parameter int N_FULL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FULL-1:0] req_full,
  input  logic              req_local,
  output logic              flush_all,
  output logic              flush_local
);

  logic any_full;
  assign any_full = |req_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_all   <= 1'b0;
      flush_local <= 1'b0;
    end else begin
      flush_all   <= any_full;
      flush_local <= req_local && !any_full;
    end
  end

endmodule

// File: rtl/pgctl_unit.sv
module pgctl_unit
  import pgctl_pkg::*;
#(
  parameter int BASE_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int GATE_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [REG_W-1:0]  mode_wdata,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic              ext_we,
  input  logic [REG_W-1:0]  ext_wdata,
  input  logic              simd_avail,
  input  logic              gate_we,
  input  logic              gate_val,
  output logic [REG_W-1:0]  mode_q,
  output logic [BASE_W-1:0] base_q,
  output logic [REG_W-1:0]  ext_q,
  output logic              real_mode,
  output logic              cop_mon,
  output logic              fpu_emul,
  output logic              task_sw,
  output logic              ext_state_en,
  output logic [ADDR_W-1:0] addr_mask,
  output logic              flush_all,
  output logic              flush_local
);

  localparam int N_FULL = 3;

  // named internal events
  logic        mode_req_full;
  logic        ext_req_full;
  logic        gate_req_full;
  logic        base_req_local;
  logic        pg_en;
  logic        gate_q;
  mode_flags_t flags;

  pgctl_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mode_we),
    .wdata    (mode_wdata),
    .mode_q   (mode_q),
    .pg_en    (pg_en),
    .flags    (flags),
    .req_full (mode_req_full)
  );

  pgctl_ext_reg u_ext (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (ext_we),
    .wdata        (ext_wdata),
    .simd_avail   (simd_avail),
    .ext_q        (ext_q),
    .ext_state_en (ext_state_en),
    .req_full     (ext_req_full)
  );

  pgctl_gate_reg #(.ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (gate_we),
    .val      (gate_val),
    .gate_q   (gate_q),
    .mask     (addr_mask),
    .req_full (gate_req_full)
  );

  // table-base register; paging state is the value held before this edge
  assign base_req_local = base_we && pg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  pgctl_flush_arb #(.N_FULL(N_FULL)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_full    ({gate_req_full, ext_req_full, mode_req_full}),
    .req_local   (base_req_local),
    .flush_all   (flush_all),
    .flush_local (flush_local)
  );

  assign real_mode = flags.real_mode;
  assign cop_mon   = flags.cop_mon;
  assign fpu_emul  = flags.fpu_emul;
  assign task_sw   = flags.task_sw;

endmodule

// File: rtl/pgctl_unit_chk.sv
module pgctl_unit_chk #(
  parameter int ADDR_W   = 32,
  parameter int GATE_BIT = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic [31:0]       mode_wdata,
  input logic              base_we,
  input logic              ext_we,
  input logic              simd_avail,
  input logic              gate_we,
  input logic              gate_val,
  input logic [31:0]       mode_q,
  input logic [31:0]       ext_q,
  input logic              real_mode,
  input logic [ADDR_W-1:0] addr_mask,
  input logic              flush_all,
  input logic              flush_local,
  input logic              mode_req_full,
  input logic              base_req_local
);

  logic any_we;
  assign any_we = mode_we || base_we || ext_we || gate_we;

  // R2: bit 4 reads 1 after any mode write
  p_et_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_q[4]);

  // R3: a flip of paging-on leads to a full flush
  p_pg_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && (mode_wdata[31] != mode_q[31])) |=> flush_all);

  // R4: base write with paging off and nothing else written: no flush
  p_base_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && !mode_q[31] && !mode_we && !ext_we && !gate_we) |=> (!flush_all && !flush_local));

  // R6: without SIMD the extended state bit is stored as 0
  p_simd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && !simd_avail) |=> !ext_q[9]);

  // R7: rewriting the held gate state changes neither mask nor flush
  p_gate_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_we && (gate_val == addr_mask[GATE_BIT]) && !mode_we && !ext_we && !base_we)
      |=> (!flush_all && !flush_local && $stable(addr_mask)));

  // R8: real mode flag opposes protection bit
  p_real_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    real_mode != mode_q[0]);

  // R9: no write, no pulse next cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_we |=> (!flush_all && !flush_local));

  // R9: both requests in one cycle give only the full flush
  p_full_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_full && base_req_local) |=> (flush_all && !flush_local));

  // R9: the two pulses never overlap
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_all, flush_local}));

endmodule

bind pgctl_unit pgctl_unit_chk #(.ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_we        (mode_we),
  .mode_wdata     (mode_wdata),
  .base_we        (base_we),
  .ext_we         (ext_we),
  .simd_avail     (simd_avail),
  .gate_we        (gate_we),
  .gate_val       (gate_val),
  .mode_q         (mode_q),
  .ext_q          (ext_q),
  .real_mode      (real_mode),
  .addr_mask      (addr_mask),
  .flush_all      (flush_all),
  .flush_local    (flush_local),
  .mode_req_full  (mode_req_full),
  .base_req_local (base_req_local)
);

// File: tb/pgctl_unit_bench.sv
module pgctl_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        ext_we = 1'b0;
  logic [31:0] ext_wdata = '0;
  logic        simd_avail = 1'b1;
  logic        gate_we = 1'b0;
  logic        gate_val = 1'b1;
  logic [31:0] mode_q, base_q, ext_q, addr_mask;
  logic        real_mode, cop_mon, fpu_emul, task_sw, ext_state_en;
  logic        flush_all, flush_local;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgctl_unit u_pgctl_unit (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .ext_we(ext_we), .ext_wdata(ext_wdata),
    .simd_avail(simd_avail),
    .gate_we(gate_we), .gate_val(gate_val),
    .mode_q(mode_q), .base_q(base_q), .ext_q(ext_q),
    .real_mode(real_mode), .cop_mon(cop_mon), .fpu_emul(fpu_emul),
    .task_sw(task_sw), .ext_state_en(ext_state_en),
    .addr_mask(addr_mask), .flush_all(flush_all), .flush_local(flush_local)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] mode;
    logic [31:0] base;
    logic [31:0] ext;
    logic [31:0] mask;
    logic        fa;
    logic        fl;
    logic [4:0]  flags;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // bench's own model of the stored state
  logic [31:0] m_mode = 32'h6000_0010;
  logic [31:0] m_base = '0;
  logic [31:0] m_ext  = '0;
  logic        m_gate = 1'b1;

  task automatic cmp(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, then push the expected outcome
  task automatic step(input int req,
                      input logic mw, input logic [31:0] md,
                      input logic bw, input logic [31:0] bd,
                      input logic ew, input logic [31:0] ed,
                      input logic gw, input logic gv, input logic simd);
    exp_t e;
    logic full, loc;
    mode_we = mw; mode_wdata = md;
    base_we = bw; base_wdata = bd;
    ext_we = ew;  ext_wdata = ed;
    gate_we = gw; gate_val = gv;
    simd_avail = simd;
    @(posedge clk);
    #1;
    mode_we = 1'b0; base_we = 1'b0; ext_we = 1'b0; gate_we = 1'b0;
    full = 1'b0;
    loc  = 1'b0;
    if (mw) begin
      if (((md ^ m_mode) & 32'h8001_0001) != 0) full = 1'b1;     // R3
    end
    if (bw && m_mode[31]) loc = 1'b1;                             // R4
    if (ew) begin
      if (((ed ^ m_ext) & 32'h0000_00B0) != 0) full = 1'b1;      // R5
    end
    if (gw && (gv != m_gate)) full = 1'b1;                        // R7
    if (mw) m_mode = md | 32'h0000_0010;                          // R2
    if (bw) m_base = bd;
    if (ew) m_ext = simd ? ed : (ed & ~32'h0000_0200);            // R6
    if (gw) m_gate = gv;
    e.req   = 4'(req);
    e.mode  = m_mode;
    e.base  = m_base;
    e.ext   = m_ext;
    e.mask  = m_gate ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
    e.fa    = full;
    e.fl    = loc && !full;                                       // R9
    e.flags = {~m_mode[0], m_mode[1], m_mode[2], m_mode[3], m_ext[9]}; // R8
    exp_q.push_back(e);
  endtask

  task automatic idle(input int req);
    step(req, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, m_gate, simd_avail);
  endtask

  // monitor: pops and compares one item per cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(int'(e.req), "mode_q", mode_q, e.mode);
        cmp(int'(e.req), "base_q", base_q, e.base);
        cmp(int'(e.req), "ext_q", ext_q, e.ext);
        cmp(int'(e.req), "addr_mask", addr_mask, e.mask);
        cmp(int'(e.req), "flush{all,local}", {30'd0, flush_all, flush_local}, {30'd0, e.fa, e.fl});
        cmp(int'(e.req), "flags", {27'd0, real_mode, cop_mon, fpu_emul, task_sw, ext_state_en},
            {27'd0, e.flags});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle(1);
    // R3: rewrite with identical watched bits -> no flush
    step(3, 1'b1, 32'h6000_0010, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R2: bit 4 forced even when written 0; watched bits unchanged
    step(2, 1'b1, 32'h0000_0000, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R3: protection bit flips -> full flush
    step(3, 1'b1, 32'h0000_0001, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R9: pulse ends
    idle(9);
    // R3: write-protect flips alone
    step(3, 1'b1, 32'h0001_0001, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R4: base write with paging off -> no flush
    step(4, 1'b0, '0, 1'b1, 32'h1234_5000, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R3: paging on
    step(3, 1'b1, 32'h8001_0001, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R4: base write with paging on -> non-global flush
    step(4, 1'b0, '0, 1'b1, 32'hABCD_E000, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    idle(9);
    // R4: back-to-back base writes pulse each cycle
    step(4, 1'b0, '0, 1'b1, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    step(4, 1'b0, '0, 1'b1, 32'h0000_2000, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R9: base and extension (bit 5 change) together -> full only
    step(9, 1'b0, '0, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_0020, 1'b0, 1'b1, 1'b1);
    // R4: mode write turning paging off in same cycle as base write: old paging state counts
    step(4, 1'b1, 32'h0001_0001, 1'b1, 32'h0000_4000, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    step(4, 1'b0, '0, 1'b1, 32'h0000_5000, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    step(3, 1'b1, 32'h8001_0001, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R6 R8: bit 9 kept with SIMD, no flush
    step(6, 1'b0, '0, 1'b0, '0, 1'b1, 32'h0000_0220, 1'b0, 1'b1, 1'b1);
    // R6: bit 9 cleared without SIMD
    step(6, 1'b0, '0, 1'b0, '0, 1'b1, 32'h0000_0220, 1'b0, 1'b1, 1'b0);
    // R5: global-page bit change
    step(5, 1'b0, '0, 1'b0, '0, 1'b1, 32'h0000_00A0, 1'b0, 1'b1, 1'b1);
    // R5: large-page bit change
    step(5, 1'b0, '0, 1'b0, '0, 1'b1, 32'h0000_00B0, 1'b0, 1'b1, 1'b1);
    // R5: unwatched bit change -> no flush
    step(5, 1'b0, '0, 1'b0, '0, 1'b1, 32'h0000_00B4, 1'b0, 1'b1, 1'b1);
    // R8: flags follow bits 0..3
    step(8, 1'b1, 32'h8001_000E, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    step(8, 1'b1, 32'h8001_0005, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    // R7: gate rewritten with held state
    step(7, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b1, 1'b1);
    // R7: gate closes
    step(7, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b1);
    step(7, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b1);
    // R7: gate opens
    step(7, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b1, 1'b1);
    idle(9);
    idle(9);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule